// File: doc/BRIEF.md
# Match-Compare Timer with PWM

This block is a free-running up-counter with a programmable clock prescaler and four compare channels. Each channel holds a compare value and, when the counter equals it on a count step, can flag an interrupt, return the counter to zero, or halt counting. Independently of those internal actions, every channel owns an output pin whose level a 2-bit action field leaves alone, drives low, drives high or inverts on each match.

In PWM mode, the first three channels produce pulse-width-modulated outputs. The last channel acts as the period register: it always restarts the counter on its match, whatever its own action field says. All settings live behind a simple synchronous register port: a write strobe with address and data, and a combinational read-data bus selected by the same address.

Top module: `match_pwm_timer`

## Requirements
- R1: While control bit 0 (enable) is 1 and control bit 1 (hold-clear) is 0, the count rises by one every PRESC+1 clock cycles. PRESC is the prescale register. The prescaler treats any internal value at or above PRESC as terminal.
- R2: A match happens on a count step where the count equals a channel's compare value. If bit 3c+1 of the match-action register is set for channel c, that match loads zero instead of count+1.
- R3: If bit 3c+2 of the match-action register is set, a match on channel c clears the enable bit. That step still applies its increment, and the count then holds. A register write to control in the same cycle takes priority.
- R4: If bit 3c of the match-action register is set, a match on channel c sets flag c in bits 0-3 of the flag register. Writing 1 to a flag bit clears it, but a set in the same cycle wins. `irq` is high while any flag is set.
- R5: The output-action field at bits 4+2c..5+2c of the output register acts on every match of channel c: 0 keeps `match_out[c]`, 1 clears it, 2 sets it, 3 inverts it. Bits 0-3 of the same register read and write the output levels directly, and a software write wins over a match.
- R6: With enable 0, both the count and the prescaler hold their values.
- R7: While hold-clear is 1, the count and the prescaler are held at zero and no match occurs.
- R8: Bit p (p=0..2) of the PWM register enables `pwm_out[p]`. The output is low while the count is below compare value p, and high at or above it. While any PWM bit is set, a match on channel 3 returns the count to zero.
- R9: While compare value 3 is zero, all PWM outputs are low.
- R10: The register addresses are: flags 0, control 1, count 2 (read-only), prescale 3, match-action 4, output 5, PWM 6, compare values 8-11. A compare value can be written at any time and applies from the next cycle. Writes to read-only or unmapped addresses have no effect, and unmapped reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| match_out | output | NUM_CH | Per-channel match output levels |
| pwm_out | output | NUM_CH-1 | PWM outputs |
| irq | output | 1 | OR of the match flags |

## Verification
The bound checker checks these rules on every cycle: single-step counting and frozen counting, zeroing under hold-clear and on a reset match, enable loss after a stop match, the interrupt after an interrupting match, inversion of an output on a toggle match, and silent PWM with a zero period. The exact prescaler phase and the duty cycle of each PWM output can only be shown by the bench scenarios. So can the interaction of simultaneous software writes with match actions, and the handling of writes to read-only addresses. These are compared each cycle against a bench model of the register semantics.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int ADR_W = 4;

   localparam logic [ADR_W-1:0] A_FLAGS  = 4'd0;
   localparam logic [ADR_W-1:0] A_CTRL   = 4'd1;
   localparam logic [ADR_W-1:0] A_COUNT  = 4'd2;
   localparam logic [ADR_W-1:0] A_PRESC  = 4'd3;
   localparam logic [ADR_W-1:0] A_MCTL   = 4'd4;
   localparam logic [ADR_W-1:0] A_EXT    = 4'd5;
   localparam logic [ADR_W-1:0] A_PWM    = 4'd6;
   localparam logic [ADR_W-1:0] A_MATCH0 = 4'd8;

   // bit positions inside a channel's 3-bit match-action field
   localparam int MC_IRQ  = 0;
   localparam int MC_RST  = 1;
   localparam int MC_STOP = 2;

   // first bit of the output-action fields in the output register
   localparam int EXT_ACT_LSB = 4;

   typedef enum logic [1:0] {
      EXT_KEEP = 2'd0,
      EXT_CLR  = 2'd1,
      EXT_SET  = 2'd2,
      EXT_TGL  = 2'd3
   } ext_act_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PRE_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clear,
   input  logic [PRE_W-1:0] limit,
   output logic             tick
);
   logic [PRE_W-1:0] pcnt_q;
   logic             terminal;

   assign terminal = (pcnt_q >= limit);
   assign tick     = run && !clear && terminal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
      end else if (clear) begin
         pcnt_q <= '0;
      end else if (run) begin
         pcnt_q <= terminal ? '0 : pcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             live,
   input  logic [CNT_W-1:0] count,
   input  logic             mval_we,
   input  logic [CNT_W-1:0] mval_wd,
   input  logic [2:0]       ctl,
   input  ext_act_e         act,
   input  logic             state_we,
   input  logic             state_wd,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] mval,
   output logic             hit,
   output logic             flag,
   output logic             ext_q
);
   logic ext_next;

   assign hit = live && (count == mval);

   always_comb begin
      ext_next = ext_q;
      if (hit) begin
         unique case (act)
            EXT_KEEP: ext_next = ext_q;
            EXT_CLR:  ext_next = 1'b0;
            EXT_SET:  ext_next = 1'b1;
            EXT_TGL:  ext_next = ~ext_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mval  <= '0;
         flag  <= 1'b0;
         ext_q <= 1'b0;
      end else begin
         if (mval_we) mval <= mval_wd;
         flag  <= (flag && !flag_clr) || (hit && ctl[MC_IRQ]);
         ext_q <= state_we ? state_wd : ext_next;
      end
   end
endmodule

// File: rtl/tmr_pwm_bank.sv
module tmr_pwm_bank #(
   parameter int CNT_W = 32,
   parameter int NPWM  = 3
) (
   input  logic [CNT_W-1:0]           count,
   input  logic [CNT_W-1:0]           period,
   input  logic [NPWM-1:0]            en,
   input  logic [NPWM-1:0][CNT_W-1:0] thr,
   output logic [NPWM-1:0]            pwm
);
   logic period_ok;
   assign period_ok = (period != '0);

   for (genvar p = 0; p < NPWM; p++) begin : g_pwm
      assign pwm[p] = en[p] && period_ok && (count >= thr[p]);
   end
endmodule

// File: rtl/match_pwm_timer.sv
module match_pwm_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int PRE_W   = 32,
   parameter int NUM_CH  = 4,
   parameter int DW      = 32,
   parameter bit HAS_PWM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADR_W-1:0]  reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic [NUM_CH-1:0] match_out,
   output logic [NUM_CH-2:0] pwm_out,
   output logic              irq
);
   localparam int NPWM  = NUM_CH - 1;
   localparam int LAST  = NUM_CH - 1;
   localparam int MC_W  = 3 * NUM_CH;
   localparam int ACT_W = 2 * NUM_CH;

   if (NUM_CH < 2 || NUM_CH > 4) begin : g_bad_ch
      $error("NUM_CH must lie in 2..4");
   end
   if (CNT_W > DW || PRE_W > DW) begin : g_bad_w
      $error("CNT_W and PRE_W must fit in DW");
   end
   if (DW < EXT_ACT_LSB + ACT_W || DW < MC_W) begin : g_bad_dw
      $error("DW too narrow for the control fields");
   end

   logic                         en_q, crst_q;
   logic [CNT_W-1:0]             cnt_q;
   logic [PRE_W-1:0]             pre_q;
   logic [MC_W-1:0]              mctl_q;
   logic [ACT_W-1:0]             act_q;
   logic [NPWM-1:0]              pwm_q;
   logic                         live;
   logic [NUM_CH-1:0]            hit, rst_req, stop_req, flags, ext_q;
   logic [NUM_CH-1:0][CNT_W-1:0] mval_all;
   logic                         pwm_any;
   logic                         wr_flags, wr_ctrl, wr_presc, wr_mctl, wr_ext, wr_pwm;

   assign wr_flags = reg_wr && (reg_addr == A_FLAGS);
   assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
   assign wr_presc = reg_wr && (reg_addr == A_PRESC);
   assign wr_mctl  = reg_wr && (reg_addr == A_MCTL);
   assign wr_ext   = reg_wr && (reg_addr == A_EXT);
   assign wr_pwm   = reg_wr && (reg_addr == A_PWM);
   assign pwm_any  = HAS_PWM && (|pwm_q);

   tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en_q),
      .clear (crst_q),
      .limit (pre_q),
      .tick  (live)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tmr_match_chan #(.CNT_W(CNT_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .live     (live),
         .count    (cnt_q),
         .mval_we  (reg_wr && (reg_addr == A_MATCH0 + ADR_W'(c))),
         .mval_wd  (reg_wdata[CNT_W-1:0]),
         .ctl      (mctl_q[3*c +: 3]),
         .act      (ext_act_e'(act_q[2*c +: 2])),
         .state_we (wr_ext),
         .state_wd (reg_wdata[c]),
         .flag_clr (wr_flags && reg_wdata[c]),
         .mval     (mval_all[c]),
         .hit      (hit[c]),
         .flag     (flags[c]),
         .ext_q    (ext_q[c])
      );
      if (c == LAST) begin : g_period
         assign rst_req[c] = hit[c] && (mctl_q[3*c + MC_RST] || pwm_any);
      end else begin : g_plain
         assign rst_req[c] = hit[c] && mctl_q[3*c + MC_RST];
      end
      assign stop_req[c] = hit[c] && mctl_q[3*c + MC_STOP];
   end

   if (HAS_PWM) begin : g_pwm_on
      tmr_pwm_bank #(.CNT_W(CNT_W), .NPWM(NPWM)) u_pwm (
         .count  (cnt_q),
         .period (mval_all[LAST]),
         .en     (pwm_q),
         .thr    (mval_all[NPWM-1:0]),
         .pwm    (pwm_out)
      );
   end else begin : g_pwm_off
      assign pwm_out = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         crst_q <= 1'b0;
         cnt_q  <= '0;
         pre_q  <= '0;
         mctl_q <= '0;
         act_q  <= '0;
         pwm_q  <= '0;
      end else begin
         if (crst_q)     cnt_q <= '0;
         else if (live)  cnt_q <= (|rst_req) ? '0 : cnt_q + 1'b1;

         if (wr_ctrl) begin
            en_q   <= reg_wdata[0];
            crst_q <= reg_wdata[1];
         end else if (|stop_req) begin
            en_q   <= 1'b0;
         end

         if (wr_presc) pre_q  <= reg_wdata[PRE_W-1:0];
         if (wr_mctl)  mctl_q <= reg_wdata[MC_W-1:0];
         if (wr_ext)   act_q  <= reg_wdata[EXT_ACT_LSB +: ACT_W];
         if (wr_pwm)   pwm_q  <= reg_wdata[NPWM-1:0];
      end
   end

   assign match_out = ext_q;
   assign irq       = |flags;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_FLAGS: reg_rdata[NUM_CH-1:0] = flags;
         A_CTRL:  reg_rdata[1:0]        = {crst_q, en_q};
         A_COUNT: reg_rdata[CNT_W-1:0]  = cnt_q;
         A_PRESC: reg_rdata[PRE_W-1:0]  = pre_q;
         A_MCTL:  reg_rdata[MC_W-1:0]   = mctl_q;
         A_EXT: begin
            reg_rdata[NUM_CH-1:0]              = ext_q;
            reg_rdata[EXT_ACT_LSB +: ACT_W]    = act_q;
         end
         A_PWM:   reg_rdata[NPWM-1:0]   = pwm_q;
         default: begin
            for (int c = 0; c < NUM_CH; c++) begin
               if (reg_addr == A_MATCH0 + ADR_W'(c)) reg_rdata[CNT_W-1:0] = mval_all[c];
            end
         end
      endcase
   end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADR_W-1:0]  reg_addr,
   input logic [NUM_CH-1:0] match_out,
   input logic [NUM_CH-2:0] pwm_out,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              en_q,
   input logic              crst_q,
   input logic              live,
   input logic [NUM_CH-1:0] hit,
   input logic [NUM_CH-1:0] rst_req,
   input logic [NUM_CH-1:0] stop_req,
   input logic [3*NUM_CH-1:0] mctl_q,
   input logic [2*NUM_CH-1:0] act_q,
   input logic [CNT_W-1:0]  period
);
   logic [NUM_CH-1:0] irq_hit;
   logic              ctrl_wr, ext_wr;

   always_comb begin
      for (int c = 0; c < NUM_CH; c++) irq_hit[c] = hit[c] && mctl_q[3*c + MC_IRQ];
   end
   assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
   assign ext_wr  = reg_wr && (reg_addr == A_EXT);

   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !(|rst_req) && !crst_q) |=> (cnt_q == $past(cnt_q) + 1'b1));

   p_reset_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|rst_req) |=> (cnt_q == '0));

   p_stop_clears_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((|stop_req) && !ctrl_wr) |=> !en_q);

   p_flag_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_hit) |=> irq);

   p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !crst_q) |=> $stable(cnt_q));

   p_hold_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      crst_q |=> (cnt_q == '0));

   p_zero_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (period == '0) |-> (pwm_out == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_tgl
      p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[c] && (act_q[2*c +: 2] == 2'd3) && !ext_wr) |=> (match_out[c] != $past(match_out[c])));
   end
endmodule

bind match_pwm_timer tmr_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .match_out (match_out),
   .pwm_out   (pwm_out),
   .irq       (irq),
   .cnt_q     (cnt_q),
   .en_q      (en_q),
   .crst_q    (crst_q),
   .live      (live),
   .hit       (hit),
   .rst_req   (rst_req),
   .stop_req  (stop_req),
   .mctl_q    (mctl_q),
   .act_q     (act_q),
   .period    (mval_all[NUM_CH-1])
);

// File: tb/match_pwm_timer_tb.sv
`timescale 1ns/1ps
module match_pwm_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = 4'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic [3:0]  match_out;
   logic [2:0]  pwm_out;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit mon_on  = 1'b0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   match_pwm_timer u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .match_out(match_out),
      .pwm_out(pwm_out), .irq(irq)
   );

   // reference state, updated from the requirement rules
   bit          m_en, m_crst;
   int unsigned m_pre, m_pcnt, m_cnt;
   bit [11:0]   m_mctl;
   bit [7:0]    m_act;
   bit [3:0]    m_ext, m_flags;
   bit [2:0]    m_pwm;
   int unsigned m_match [4];

   task automatic model_reset();
      m_en = 0; m_crst = 0; m_pre = 0; m_pcnt = 0; m_cnt = 0;
      m_mctl = 0; m_act = 0; m_ext = 0; m_flags = 0; m_pwm = 0;
      for (int c = 0; c < 4; c++) m_match[c] = 0;
   endtask

   task automatic model_step(bit wr, bit [3:0] a, bit [31:0] d);
      bit live, rreq, sreq;
      bit [3:0] hit, n_ext, clr;
      live = m_en && !m_crst && (m_pcnt >= m_pre);
      rreq = 0; sreq = 0;
      for (int c = 0; c < 4; c++) begin
         hit[c] = live && (m_cnt == m_match[c]);
         if (hit[c] && (m_mctl[3*c+1] || (c == 3 && m_pwm != 0))) rreq = 1;
         if (hit[c] && m_mctl[3*c+2]) sreq = 1;
      end
      n_ext = m_ext;
      for (int c = 0; c < 4; c++) begin
         if (hit[c]) begin
            case (m_act[2*c +: 2])
               2'd1: n_ext[c] = 1'b0;
               2'd2: n_ext[c] = 1'b1;
               2'd3: n_ext[c] = ~m_ext[c];
               default: ;
            endcase
         end
      end
      clr = (wr && a == 4'd0) ? d[3:0] : 4'd0;
      for (int c = 0; c < 4; c++)
         m_flags[c] = (m_flags[c] && !clr[c]) || (hit[c] && m_mctl[3*c]);
      if (m_crst) m_cnt = 0;
      else if (live) m_cnt = rreq ? 0 : m_cnt + 1;
      if (m_crst) m_pcnt = 0;
      else if (m_en) m_pcnt = (m_pcnt >= m_pre) ? 0 : m_pcnt + 1;
      if (wr && a == 4'd1) begin m_en = d[0]; m_crst = d[1]; end
      else if (sreq) m_en = 0;
      if (wr && a == 4'd3) m_pre = d;
      if (wr && a == 4'd4) m_mctl = d[11:0];
      if (wr && a == 4'd5) begin m_ext = d[3:0]; m_act = d[11:4]; end
      else m_ext = n_ext;
      if (wr && a == 4'd6) m_pwm = d[2:0];
      for (int c = 0; c < 4; c++) if (wr && a == 4'(8 + c)) m_match[c] = d;
   endtask

   function automatic bit [31:0] model_read(bit [3:0] a);
      case (a)
         4'd0: return {28'd0, m_flags};
         4'd1: return {30'd0, m_crst, m_en};
         4'd2: return m_cnt;
         4'd3: return m_pre;
         4'd4: return {20'd0, m_mctl};
         4'd5: return {20'd0, m_act, m_ext};
         4'd6: return {29'd0, m_pwm};
         4'd8, 4'd9, 4'd10, 4'd11: return m_match[a - 4'd8];
         default: return 32'd0;
      endcase
   endfunction

   function automatic bit [2:0] model_pwm();
      bit [2:0] p;
      for (int c = 0; c < 3; c++) p[c] = m_pwm[c] && (m_match[3] != 0) && (m_cnt >= m_match[c]);
      return p;
   endfunction

   function automatic string addr_tag(bit [3:0] a);
      case (a)
         4'd0: return "R4";
         4'd1: return "R3";
         4'd2: return "R1";
         4'd5: return "R5";
         4'd6: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else model_step(reg_wr, reg_addr, reg_wdata);
   end

   always @(negedge clk) begin
      if (mon_on) begin
         #2;
         check("R5", "match_out", {28'd0, match_out}, {28'd0, m_ext});
         check("R8", "pwm_out", {29'd0, pwm_out}, {29'd0, model_pwm()});
         check("R4", "irq", {31'd0, irq}, {31'd0, |m_flags});
         check(addr_tag(reg_addr), "rdata", reg_rdata, model_read(reg_addr));
      end
   end

   task automatic wr(bit [3:0] a, bit [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = 32'd0;
   endtask

   task automatic rd(bit [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #3;
      d = reg_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v1, v2;
      int h0, h1, h2;
      void'($urandom(32'h00C0FFEE));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;

      // reset state
      rd(4'd1, v1); check("R10", "reset control", v1, 32'd0);
      rd(4'd2, v1); check("R1", "reset count", v1, 32'd0);
      check("R4", "reset irq", {31'd0, irq}, 32'd0);
      check("R5", "reset match_out", {28'd0, match_out}, 32'd0);

      // R1 prescaled counting, R6 freeze
      wr(4'd3, 32'd2);
      wr(4'd1, 32'd1);
      idle(30);
      wr(4'd1, 32'd0);
      rd(4'd2, v1);
      check("R1", "prescaled count in range", {31'd0, (v1 >= 9 && v1 <= 12)}, 32'd1);
      idle(10);
      rd(4'd2, v2);
      check("R6", "frozen count", v2, v1);

      // R7 hold-clear
      wr(4'd1, 32'd3);
      idle(4);
      rd(4'd2, v1);
      check("R7", "held count", v1, 32'd0);

      // R2 reset match, R4 interrupt, R5 toggle on channel 0
      wr(4'd3, 32'd0);
      wr(4'd8, 32'd5);
      wr(4'd4, 32'h003);
      wr(4'd5, 32'h030);
      wr(4'd1, 32'd1);
      idle(40);
      check("R4", "irq after match", {31'd0, irq}, 32'd1);
      rd(4'd2, v1);
      check("R2", "count bounded by reset match", {31'd0, v1 <= 5}, 32'd1);
      wr(4'd4, 32'h000);
      wr(4'd0, 32'h00F);
      @(negedge clk); #3;
      check("R4", "irq after flag clear", {31'd0, irq}, 32'd0);

      // R3 stop on channel 1
      wr(4'd9, 32'd7);
      wr(4'd4, 32'h020);
      wr(4'd1, 32'd2);
      wr(4'd1, 32'd1);
      idle(20);
      rd(4'd1, v1); check("R3", "enable cleared by stop", v1, 32'd0);
      rd(4'd2, v1); check("R3", "count after stop", v1, 32'd8);

      // R8 PWM, R9 zero period
      wr(4'd4, 32'h000);
      wr(4'd5, 32'h000);
      wr(4'd8, 32'd3);
      wr(4'd9, 32'd0);
      wr(4'd10, 32'd12);
      wr(4'd11, 32'd9);
      wr(4'd6, 32'd7);
      wr(4'd1, 32'd2);
      wr(4'd1, 32'd1);
      idle(12);
      h0 = 0; h1 = 0; h2 = 0;
      repeat (20) begin
         @(negedge clk); #3;
         h0 += pwm_out[0]; h1 += pwm_out[1]; h2 += pwm_out[2];
      end
      check("R8", "pwm0 high cycles", h0, 32'd14);
      check("R8", "pwm1 high cycles", h1, 32'd20);
      check("R8", "pwm2 high cycles", h2, 32'd0);
      rd(4'd2, v1);
      check("R8", "period bounds count", {31'd0, v1 <= 9}, 32'd1);
      wr(4'd11, 32'd0);
      @(negedge clk); #3;
      check("R9", "pwm with zero period", {29'd0, pwm_out}, 32'd0);

      // R10 read-only count and unmapped reads
      wr(4'd1, 32'd0);
      rd(4'd2, v1);
      wr(4'd2, 32'd1234);
      rd(4'd2, v2);
      check("R10", "count write ignored", v2, v1);
      wr(4'd7, 32'hFFFF);
      rd(4'd7, v2);
      check("R10", "unmapped read", v2, 32'd0);

      // constrained random traffic, checked every cycle by the monitor
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if ($urandom % 5 == 0) begin
            bit [3:0]  a;
            bit [31:0] d;
            a = 4'($urandom % 16);
            case (a)
               4'd1:  d = ($urandom % 8 == 0) ? 32'd3 : (($urandom % 6 == 0) ? 32'd0 : 32'd1);
               4'd3:  d = $urandom % 3;
               4'd4, 4'd5: d = $urandom & 32'hFFF;
               4'd6:  d = $urandom % 8;
               4'd0:  d = $urandom % 16;
               4'd8, 4'd9, 4'd10, 4'd11: d = $urandom % 16;
               default: d = $urandom;
            endcase
            reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
         end else begin
            reg_wr = 1'b0;
            reg_addr = 4'($urandom % 16);
         end
      end
      @(negedge clk);
      reg_wr = 1'b0;
      idle(3);
      mon_on = 1'b0;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule